// File: doc/BRIEF.md
# Serial-Loaded Switch-Enable Register with Cascade Output

This block is the logic front end of a bank of independently controlled switches. A pattern arrives one bit at a time on a serial input and moves through a shift chain that is as long as there are switches. A bank of level-sensitive latches sits between the chain and the switch-enable outputs. While the active-low latch-enable input is low, the latches pass the chain contents straight through. On its rising edge they freeze. An asynchronous, active-high clear turns every switch off without touching the shift chain.

In normal use, latch enable is held high while a complete pattern is shifted in, so that the switches do not see the bits as they move. Latch enable is then pulsed low and back high to apply the pattern. The serial output carries the last stage of the chain, so several devices can be wired in a daisy chain and loaded with one long stream.

The serial input is a valid/ready stream with one bit per beat. A beat is accepted on any rising clock edge where `sdi_valid` is high. `sdi_ready` is always high, so the block never applies back-pressure. Latch enable, clear and the serial output are plain level signals.

Top module: `swc_serial_ctrl`

## Requirements
- R1: The block has 16 switch-enable outputs (parameter CH). Latch bit i drives `sw_en[i]` and only that output. Each bit is set by its own stage, independently of the others.
- R2: On a rising clock edge with `sdi_valid` high, `sdi_data` is loaded into stage 0 and every stage k moves into stage k+1. With `sdi_valid` low, the chain holds. `sdi_ready` is always 1.
- R3: While `le_n` is low and `clr` is low, `sw_en` equals the chain contents and follows each shift in the same cycle.
- R4: On the rising edge of `le_n`, `sw_en` captures the chain contents present at that moment and keeps them.
- R5: While `le_n` is high, shifting the chain does not change `sw_en`.
- R6: `sdo` equals stage 15 (stage CH-1). The first bit shifted in appears on `sdo` after 16 accepted beats and controls `sw_en[15]` when applied.
- R7: While `clr` is high, `sw_en` is all zero, whatever `le_n`, the clock or the data do. If `le_n` is high when `clr` falls, the outputs stay zero.
- R8: While `rst_n` is low, the chain and the latches are zero, so `sw_en` and `sdo` are 0.
- R9: `clr` does not change the chain. Shifting continues during clear, and `sdo` keeps showing stage 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; bits are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of chain and latches |
| sdi_valid | input | 1 | Serial beat present |
| sdi_data | input | 1 | Serial data bit |
| sdi_ready | output | 1 | Always 1; the block never stalls the stream |
| le_n | input | 1 | Latch enable, active low: low = transparent, rising edge = capture |
| clr | input | 1 | Asynchronous active-high clear of all switch enables |
| sw_en | output | CH | Switch enables, one bit per switch |
| sdo | output | 1 | Last chain stage, for cascading |

## Verification
The bench shifts a full pattern with latch enable high and confirms that the outputs do not move. A design whose latch were transparent at the wrong level would show the pattern sliding through the outputs. It then pulses the enable and checks the exact bit order on the outputs. A reversed chain would mirror the pattern, and an off-by-one chain would shift it.

Clear is applied while the latches are transparent and while shifting continues. The bench checks that the outputs read zero, that `sdo` and the chain keep moving, and that the outputs stay zero after clear falls with the enable high. A clear wired into the chain would wipe the cascade data. A latch that reloaded on the falling edge of clear would turn the switches back on. The cascade test compares `sdo` with the bit sent 16 beats earlier.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned SWC_CH_DEFAULT = 16;

  typedef enum logic [1:0] {
    SWC_HOLD   = 2'd0,
    SWC_FOLLOW = 2'd1,
    SWC_FORCED = 2'd2
  } swc_latch_mode_e;
endpackage

// File: rtl/swc_shift_chain.sv
module swc_shift_chain #(
  parameter int unsigned CH = swc_pkg::SWC_CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          ser_in,
  output logic [CH-1:0] stages
);
  for (genvar i = 0; i < CH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stages[i] <= 1'b0;
        else if (shift_en) stages[i] <= ser_in;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stages[i] <= 1'b0;
        else if (shift_en) stages[i] <= stages[i-1];
      end
      AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stages[i] == $past(stages[i-1])); // R2
    end
  end

  AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stages[0] == $past(ser_in)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stages)); // R2
endmodule

// File: rtl/swc_latch_bank.sv
module swc_latch_bank #(
  parameter int unsigned CH = swc_pkg::SWC_CH_DEFAULT
) (
  input  logic          rst_n,
  input  logic          clear,
  input  logic          open_n,
  input  logic [CH-1:0] d,
  output logic [CH-1:0] q
);
  import swc_pkg::*;

  swc_latch_mode_e mode;

  always_comb begin
    if (!rst_n || clear) mode = SWC_FORCED;
    else if (!open_n)    mode = SWC_FOLLOW;
    else                 mode = SWC_HOLD;
  end

  for (genvar i = 0; i < CH; i++) begin : g_bit
    always_latch begin
      if (mode == SWC_FORCED)      q[i] = 1'b0;
      else if (mode == SWC_FOLLOW) q[i] = d[i];
    end
  end
endmodule

// File: rtl/swc_serial_ctrl.sv
module swc_serial_ctrl #(
  parameter int unsigned CH = swc_pkg::SWC_CH_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdi_valid,
  input  logic          sdi_data,
  output logic          sdi_ready,
  input  logic          le_n,
  input  logic          clr,
  output logic [CH-1:0] sw_en,
  output logic          sdo
);
  localparam int unsigned LAST = CH - 1;

  logic [CH-1:0] chain;
  logic          beat;

  assign sdi_ready = 1'b1;
  assign beat      = sdi_valid & sdi_ready;

  swc_shift_chain #(.CH(CH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (beat),
    .ser_in   (sdi_data),
    .stages   (chain)
  );

  swc_latch_bank #(.CH(CH)) u_latch (
    .rst_n  (rst_n),
    .clear  (clr),
    .open_n (le_n),
    .d      (chain),
    .q      (sw_en)
  );

  assign sdo = chain[LAST];

  AST_CLR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> sw_en == '0); // R7
  AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && !clr) |-> sw_en == chain); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && !clr && $past(le_n) && !$past(clr)) |-> $stable(sw_en)); // R5
  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> sdo == $past(chain[LAST-1])); // R6
  AST_CLR_KEEPS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !beat) |=> $stable(chain)); // R9
endmodule

// File: tb/test_swc_serial_ctrl.sv
module test_swc_serial_ctrl;
  typedef struct {
    logic [15:0] sw;
    logic        so;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi_valid = 1'b0;
  logic sdi_data = 1'b0;
  logic le_n = 1'b1;
  logic clr = 1'b0;
  logic sdi_ready;
  logic sdo;
  logic [15:0] sw_en;

  logic [15:0] msr = '0;
  logic [15:0] mlat = '0;
  logic [31:0] hist = '0;
  exp_t scb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swc_serial_ctrl i_swc_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .sdi_valid(sdi_valid), .sdi_data(sdi_data),
    .sdi_ready(sdi_ready), .le_n(le_n), .clr(clr), .sw_en(sw_en), .sdo(sdo)
  );

  task automatic expect_now(string req);
    exp_t e;
    e.sw = mlat; e.so = msr[15]; e.req = req;
    scb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic shift_bit(logic b);
    step();
    sdi_data = b; sdi_valid = 1'b1;
    @(posedge clk); #2;
    sdi_valid = 1'b0;
    msr = {msr[14:0], b};
    hist = {hist[30:0], b};
    if (!le_n && !clr) mlat = msr;
  endtask

  task automatic set_le(logic v);
    step();
    le_n = v;
    if (!v && !clr) mlat = msr;
  endtask

  task automatic set_clr(logic v);
    step();
    clr = v;
    if (v) mlat = '0;
    else if (!le_n) mlat = msr;
  endtask

  always @(negedge clk) begin
    while (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      checks++;
      if (sw_en !== e.sw || sdo !== e.so || sdi_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s: sw_en=%h sdo=%b ready=%b expected sw_en=%h sdo=%b ready=1",
                 e.req, sw_en, sdo, sdi_ready, e.sw, e.so);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    // R8: reset state
    step(); expect_now("R8 reset");
    step(); rst_n = 1'b1; expect_now("R8 after release");

    // R5/R1/R4: load with enable high, then apply
    pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--) begin
      shift_bit(pat[i]);
      if (i % 4 == 0) expect_now("R5 hidden while loading");
    end
    expect_now("R6 first bit at sdo after 16 beats");
    set_le(1'b0); step(); set_le(1'b1); step();
    expect_now("R4 R1 pattern applied in bit order");
    if (mlat !== pat) begin
      checks++; errors++;
      $display("FAIL R1 model actual=%h expected=%h", mlat, pat);
    end

    // R2: valid low holds chain
    for (int i = 0; i < 3; i++) step();
    expect_now("R2 no beat no shift");
    for (int i = 0; i < 5; i++) shift_bit(i[0]);
    expect_now("R5 shifting with enable high");

    // R3: transparent
    set_le(1'b0); step(); expect_now("R3 transparent open");
    for (int i = 0; i < 6; i++) begin
      shift_bit(i[1]); expect_now("R3 follows each shift");
    end
    set_le(1'b1); step();
    shift_bit(1'b1); shift_bit(1'b1);
    expect_now("R4 frozen after rising edge");

    // R7/R9: clear while open and shifting
    set_le(1'b0); step();
    set_clr(1'b1); step(); expect_now("R7 clear forces zero");
    for (int i = 0; i < 4; i++) begin
      shift_bit(~i[0]); expect_now("R9 chain and sdo move under clear");
    end
    set_le(1'b1); step();
    set_clr(1'b0); step(); expect_now("R7 stays off after clear with enable high");
    shift_bit(1'b1); expect_now("R7 still off");
    set_le(1'b0); step(); expect_now("R9 chain intact after clear");
    set_le(1'b1); step();

    // R6: cascade delay of 16 beats
    for (int i = 0; i < 20; i++) begin
      shift_bit((i % 3) == 0);
      if (i >= 15) begin
        checks++;
        if (sdo !== hist[15]) begin
          errors++;
          $display("FAIL R6 cascade actual=%b expected=%b", sdo, hist[15]);
        end
      end
    end
    expect_now("R6 final cascade state");

    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule